// File: doc/BRIEF.md
# Indirect Pointer Literal-Subtract Unit

This block carries out one instruction of a small microcontroller core: it takes a six-bit unsigned literal away from one of three indirect-address pointer registers. The instruction word holds a two-bit select field. Codes 0, 1 and 2 pick the pointer for a plain subtract. Code 3 turns the instruction into a fused form. That form subtracts from pointer 2 and then returns from a subroutine, loading the program counter from the top of a return stack.

Each instruction cycle spans four clocks, driven by a free-running phase sequencer: decode, operand read, compute, writeback. The plain form takes one instruction cycle and moves the program counter on by one word. The fused form takes a second instruction cycle that does nothing. During that cycle a flush output tells the pipeline to drop the instruction it had already fetched. No status flags exist or are touched.

A push port stands in for the call logic of the wider core. It lets return addresses be placed on the stack. Pointers, the program counter and the stack depth can be read directly.

Top module: `ptrlit_top`

## Requirements
- R1: An instruction is accepted only when instrValid is high at a clock edge where phase is 0 and instrWord[15:8] equals 8'hE9. Any other word, or a word with instrValid low, leaves the pointers, the PC and the stack depth unchanged.
- R2: With select field instrWord[7:6] = 0, 1 or 2, the literal instrWord[5:0] is subtracted modulo 4096 from pointer 0, 1 or 2 respectively. The result is visible on the fourth clock edge after acceptance (the phase-3 edge). The other pointers are unchanged.
- R3: Subtracting literal 0x23 from a pointer holding 0x3FF yields 0x3DC. Subtracting past zero wraps, with no borrow output.
- R4: The plain form advances the PC by one, modulo 2^21, at the same edge as its pointer writeback.
- R5: With select field 3, the literal is subtracted from pointer 2. At that same phase-3 edge the PC takes the top stack entry and the stack depth falls by one.
- R6: After a return-form writeback, flush is high for exactly the next four clocks (one instruction cycle). An instruction offered during that cycle is ignored.
- R7: A return with an empty stack (depth 0) loads the PC with 0, leaves the depth at 0 and sets stkUnderflow. The flag then stays set until reset.
- R8: pushValid high at an edge stores pushAddr on top of the stack and raises the depth by one. The push is ignored when the stack already holds 31 entries, and also at the writeback edge of a return-form instruction.
- R9: A synchronous reset clears all pointers, the PC, the stack depth, the underflow flag, flush and phase to zero.
- R10: phase counts 0, 1, 2, 3 and then repeats, advancing by one on each clock edge out of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instrValid | input | 1 | Instruction word is valid (sampled in phase 0) |
| instrWord | input | 16 | Instruction word |
| pushValid | input | 1 | Push pushAddr onto the return stack |
| pushAddr | input | 21 | Return address to push |
| phase | output | 2 | Current phase of the instruction cycle |
| ptr0 | output | 12 | Pointer 0 |
| ptr1 | output | 12 | Pointer 1 |
| ptr2 | output | 12 | Pointer 2 |
| pcOut | output | 21 | Program counter |
| stkDepth | output | 5 | Number of entries on the return stack |
| stkUnderflow | output | 1 | Sticky flag: a return popped an empty stack |
| flush | output | 1 | Discard the already-fetched instruction (second cycle of the return form) |

## Verification
An accepted instruction shows its pointer, PC and depth results after the fourth clock edge from the acceptance edge, counting the acceptance edge, and no sooner. A push shows up in the depth one edge after it is presented. Flush rises on that same fourth edge and stays high for four clocks. Each bench task offers its word at the falling edge before a phase-0 edge and then waits exactly four falling edges before sampling. The flush and ignored-instruction checks are placed relative to that same point, so each result is read in the first stable half-cycle after the edge that produces it.

// File: rtl/ptrlit_pkg.sv
package ptrlit_pkg;
  parameter int PTR_W    = 12;
  parameter int PC_W     = 21;
  parameter int LIT_W    = 6;
  parameter int SEL_W    = 2;
  parameter int NUM_PTR  = 3;
  parameter int STK_DEPTH = 31;
  parameter int INSTR_W  = 16;
  parameter logic [7:0] OPC_HI = 8'hE9;
  localparam int SP_W    = $clog2(STK_DEPTH + 1);
  localparam int IDX_W   = $clog2(NUM_PTR);
  localparam logic [SEL_W-1:0] SEL_RET = '1;
  localparam logic [IDX_W-1:0] RET_PTR = IDX_W'(2);

  typedef struct packed {
    logic             rdEn;
    logic             procEn;
    logic             wrEn;
    logic             isRet;
    logic [IDX_W-1:0] ptrIdx;
    logic [LIT_W-1:0] lit;
  } ctrlStrobes_t;
endpackage

// File: rtl/ptrlit_ctrl.sv
module ptrlit_ctrl
  import ptrlit_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  output logic [1:0]         phase,
  output logic               flush,
  output ctrlStrobes_t       strobes
);
  logic             active;
  logic [SEL_W-1:0] selQ;
  logic [LIT_W-1:0] litQ;
  logic             flushCyc;
  logic             match;

  assign match = instrValid && !flushCyc && (instrWord[INSTR_W-1 -: 8] == OPC_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= 2'd0;
      active   <= 1'b0;
      selQ     <= '0;
      litQ     <= '0;
      flushCyc <= 1'b0;
    end else begin
      phase <= phase + 2'd1;
      if (phase == 2'd0) begin
        active <= match;
        if (match) begin
          selQ <= instrWord[LIT_W +: SEL_W];
          litQ <= instrWord[LIT_W-1:0];
        end
      end
      if (phase == 2'd3) begin
        flushCyc <= active && (selQ == SEL_RET);
      end
    end
  end

  always_comb begin
    strobes.rdEn   = active && (phase == 2'd1);
    strobes.procEn = active && (phase == 2'd2);
    strobes.wrEn   = active && (phase == 2'd3);
    strobes.isRet  = (selQ == SEL_RET);
    strobes.ptrIdx = (selQ == SEL_RET) ? RET_PTR : IDX_W'(selQ);
    strobes.lit    = litQ;
  end

  assign flush = flushCyc;
endmodule

// File: rtl/ptrlit_dp.sv
module ptrlit_dp
  import ptrlit_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     strobes,
  input  logic             pushValid,
  input  logic [PC_W-1:0]  pushAddr,
  output logic [PTR_W-1:0] ptrVal [NUM_PTR],
  output logic [PC_W-1:0]  pcVal,
  output logic [SP_W-1:0]  spVal,
  output logic             underflow
);
  logic [PTR_W-1:0] operandQ;
  logic [PTR_W-1:0] diffQ;
  logic [PC_W-1:0]  stkMem [STK_DEPTH];
  logic             doPop;
  logic             doPush;

  assign doPop  = strobes.wrEn && strobes.isRet;
  assign doPush = pushValid && !doPop && (spVal < SP_W'(STK_DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      operandQ <= '0;
      diffQ    <= '0;
    end else begin
      if (strobes.rdEn)   operandQ <= ptrVal[strobes.ptrIdx];
      if (strobes.procEn) diffQ    <= operandQ - PTR_W'(strobes.lit);
    end
  end

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst) ptrVal[i] <= '0;
      else if (strobes.wrEn && (strobes.ptrIdx == IDX_W'(i))) ptrVal[i] <= diffQ;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcVal     <= '0;
      spVal     <= '0;
      underflow <= 1'b0;
    end else if (doPop) begin
      if (spVal == '0) begin
        pcVal     <= '0;
        underflow <= 1'b1;
      end else begin
        pcVal <= stkMem[spVal - SP_W'(1)];
        spVal <= spVal - SP_W'(1);
      end
    end else begin
      if (strobes.wrEn) pcVal <= pcVal + PC_W'(1);
      if (doPush)       spVal <= spVal + SP_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) stkMem[spVal] <= pushAddr;
  end
endmodule

// File: rtl/ptrlit_top.sv
module ptrlit_top
  import ptrlit_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               pushValid,
  input  logic [PC_W-1:0]    pushAddr,
  output logic [1:0]         phase,
  output logic [PTR_W-1:0]   ptr0,
  output logic [PTR_W-1:0]   ptr1,
  output logic [PTR_W-1:0]   ptr2,
  output logic [PC_W-1:0]    pcOut,
  output logic [SP_W-1:0]    stkDepth,
  output logic               stkUnderflow,
  output logic               flush
);
  ctrlStrobes_t     strobes;
  logic [PTR_W-1:0] ptrVal [NUM_PTR];

  ptrlit_ctrl i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .instrValid (instrValid),
    .instrWord  (instrWord),
    .phase      (phase),
    .flush      (flush),
    .strobes    (strobes)
  );

  ptrlit_dp i_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .pushValid (pushValid),
    .pushAddr  (pushAddr),
    .ptrVal    (ptrVal),
    .pcVal     (pcOut),
    .spVal     (stkDepth),
    .underflow (stkUnderflow)
  );

  assign ptr0 = ptrVal[0];
  assign ptr1 = ptrVal[1];
  assign ptr2 = ptrVal[2];
endmodule

// File: rtl/ptrlit_chk.sv
module ptrlit_chk
  import ptrlit_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [1:0]         phase,
  input logic [PTR_W-1:0]   ptr0,
  input logic [PTR_W-1:0]   ptr1,
  input logic [PTR_W-1:0]   ptr2,
  input logic [PC_W-1:0]    pcOut,
  input logic [SP_W-1:0]    stkDepth,
  input logic               stkUnderflow,
  input logic               flush
);
  // R10
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (phase == $past(phase) + 2'd1));

  // R2
  write_only_q4_chk: assert property (@(posedge clk) disable iff (rst)
    (phase != 2'd3) |=> $stable({ptr0, ptr1, ptr2, pcOut}));

  // R6
  flush_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flush) |-> (phase == 2'd0));

  // R6
  flush_len_chk: assert property (@(posedge clk) disable iff (rst)
    (flush && phase == 2'd3) |=> !flush);

  // R7
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    stkUnderflow |=> stkUnderflow);

  // R7
  underflow_pc_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stkUnderflow) |-> (pcOut == '0 && stkDepth == '0));
endmodule

bind ptrlit_top ptrlit_chk i_chk (.*);

// File: tb/test_ptrlit_top.sv
module test_ptrlit_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        instrValid;
  logic [15:0] instrWord;
  logic        pushValid;
  logic [20:0] pushAddr;
  logic [1:0]  phase;
  logic [11:0] ptr0, ptr1, ptr2;
  logic [20:0] pcOut;
  logic [4:0]  stkDepth;
  logic        stkUnderflow;
  logic        flush;

  int nChecks = 0;
  int nFails  = 0;
  logic [11:0] expPtr [3];
  logic [20:0] expPc;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptrlit_top i_ptrlit_top (
    .clk(clk), .rst(rst), .instrValid(instrValid), .instrWord(instrWord),
    .pushValid(pushValid), .pushAddr(pushAddr), .phase(phase),
    .ptr0(ptr0), .ptr1(ptr1), .ptr2(ptr2), .pcOut(pcOut),
    .stkDepth(stkDepth), .stkUnderflow(stkUnderflow), .flush(flush)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkState(input string req);
    check(req, "ptr0", 32'(ptr0), 32'(expPtr[0]));
    check(req, "ptr1", 32'(ptr1), 32'(expPtr[1]));
    check(req, "ptr2", 32'(ptr2), 32'(expPtr[2]));
    check(req, "pc",   32'(pcOut), 32'(expPc));
  endtask

  // offer a word at phase 0; return at the falling edge after the phase-3 edge
  task automatic issue(input logic valid, input logic [15:0] word);
    while (phase != 2'd0) @(negedge clk);
    instrValid = valid;
    instrWord  = word;
    @(negedge clk);
    instrValid = 1'b0;
    instrWord  = 16'h0000;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [15:0] mk(input int sel, input int k);
    return {8'hE9, 2'(sel), 6'(k)};
  endfunction

  task automatic plainSub(input int sel, input int k);
    issue(1'b1, mk(sel, k));
    expPtr[sel] = expPtr[sel] - 12'(k);
    expPc = expPc + 21'd1;
  endtask

  task automatic pushOne(input logic [20:0] a);
    pushValid = 1'b1;
    pushAddr  = a;
    @(negedge clk);
    pushValid = 1'b0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expPtr[0] = '0; expPtr[1] = '0; expPtr[2] = '0;
    expPc = '0;
  endtask

  task automatic testReset();
    doReset();
    checkState("R9");
    check("R9", "depth", 32'(stkDepth), 0);
    check("R9", "underflow", 32'(stkUnderflow), 0);
    check("R9", "flush", 32'(flush), 0);
    check("R9", "phase", 32'(phase), 0);
  endtask

  task automatic testPhase();
    logic [1:0] p;
    p = phase;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R10", "phase step", 32'(phase), 32'(2'(p + 2'd1)));
      p = phase;
    end
  endtask

  task automatic testIgnore();
    issue(1'b1, 16'hE805);
    checkState("R1");
    issue(1'b0, mk(0, 5));
    checkState("R1");
    check("R1", "depth", 32'(stkDepth), 0);
  endtask

  task automatic testPlain();
    plainSub(1, 5);
    checkState("R2");
    check("R3", "wrap ptr1", 32'(ptr1), 32'h0FFB);
    check("R4", "pc", 32'(pcOut), 1);
    plainSub(2, 63);
    checkState("R2");
  endtask

  task automatic testExample();
    plainSub(0, 1);
    for (int i = 0; i < 48; i++) plainSub(0, 63);
    plainSub(0, 48);
    check("R3", "ptr0 built", 32'(ptr0), 32'h03FF);
    plainSub(0, 35);
    check("R3", "ptr0 example", 32'(ptr0), 32'h03DC);
    checkState("R4");
  endtask

  task automatic testReturn();
    pushOne(21'h012345);
    pushOne(21'h1ABCDE);
    check("R8", "depth after 2 pushes", 32'(stkDepth), 2);
    issue(1'b1, mk(3, 3));
    expPtr[2] = expPtr[2] - 12'd3;
    expPc = 21'h1ABCDE;
    checkState("R5");
    check("R5", "depth", 32'(stkDepth), 1);
    check("R6", "flush high", 32'(flush), 1);
    // offer an instruction in the flush cycle: it must be ignored
    instrValid = 1'b1;
    instrWord  = mk(1, 1);
    @(negedge clk);
    instrValid = 1'b0;
    check("R6", "flush still high", 32'(flush), 1);
    repeat (3) @(negedge clk);
    check("R6", "flush low after 4", 32'(flush), 0);
    repeat (4) @(negedge clk);
    checkState("R6");
    issue(1'b1, mk(3, 0));
    expPc = 21'h012345;
    checkState("R5");
    check("R5", "depth", 32'(stkDepth), 0);
    check("R7", "no underflow yet", 32'(stkUnderflow), 0);
    repeat (4) @(negedge clk);
    issue(1'b1, mk(3, 2));
    expPtr[2] = expPtr[2] - 12'd2;
    expPc = '0;
    checkState("R7");
    check("R7", "underflow", 32'(stkUnderflow), 1);
    check("R7", "depth", 32'(stkDepth), 0);
    repeat (4) @(negedge clk);
    plainSub(0, 1);
    check("R7", "underflow sticky", 32'(stkUnderflow), 1);
    checkState("R4");
  endtask

  task automatic testFull();
    for (int i = 0; i < 33; i++) pushOne(21'(i + 100));
    check("R8", "depth full", 32'(stkDepth), 31);
    issue(1'b1, mk(3, 0));
    expPc = 21'(130);
    checkState("R8");
    check("R8", "depth after pop", 32'(stkDepth), 30);
  endtask

  initial begin
    rst = 1'b1; instrValid = 1'b0; instrWord = '0; pushValid = 1'b0; pushAddr = '0;
    expPtr[0] = '0; expPtr[1] = '0; expPtr[2] = '0; expPc = '0;
    @(negedge clk);
    testReset();
    testPhase();
    testIgnore();
    testPlain();
    testExample();
    testReturn();
    testFull();
    testReset();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule